// File: doc/BRIEF.md
# ADC Serial Port Slave Sequencer

This block is the device-side serial port of an 8-bit, 11-channel converter. A host runs frames of eight serial clock cycles. In each frame the host shifts a 4-bit channel address in. At the same time the block shifts out the 8-bit result of the previous conversion. When the eighth clock falls, the block asks a converter for a new conversion and drives its end-of-conversion output low. The serial clock is then ignored until the converter reports done.

The serial clock and data input may be asynchronous to the converter clock `clk`. They are resampled into the `clk` domain, and so is the converter's done signal. Chip-select comes in two forms, both already filtered upstream:
- a level, `csN`, which gates the data output enable;
- a one-cycle reset pulse, `csRst`, which resynchronises the frame.

Addresses 11 to 15 all select the internal mid-scale test source. A healthy converter returns 0x80 for that source.

Top module: `adc_serial_seq`

## Requirements
- R1: Address bits are taken MSB first on rising serial clock edges. Only the first four rising edges of a frame load address; data on rising edges five to eight is ignored.
- R2: The result leaves on `dout` MSB first. The MSB is present before the first falling edge, and each falling edge advances one bit.
- R3: A frame is exactly eight serial clock cycles. The eighth falling edge raises `convReq` for one `clk` cycle, with the captured address on `convAddr`.
- R4: `doutOe` is high only while `csN` is low and no conversion is pending. It drops after the eighth falling edge even with `csN` still low.
- R5: While a conversion is pending, serial clock and data activity changes no state: no request, no output change, and no shift of the next frame.
- R6: `eoc` falls with the eighth falling edge. It rises once the synchronised `convDone` rising edge is seen, and at that point `convResult` becomes the next frame's output data.
- R7: Addresses 0 to 11 pass to `convAddr` unchanged. Addresses 12 to 15 are sent as 11, the test source, which yields 0x80.
- R8: The serial clock may stop for any time in either level inside a frame. The frame then resumes without loss.
- R9: A `csRst` pulse clears the bit count, drops any pending conversion and sets `eoc` high. A done edge that arrives in the same cycle as the pulse, or later, is discarded, and the previous result is kept.
- R10: After `rstN` the block has `eoc` high, `convReq` low and a stored result of 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all state runs on it |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Filtered chip-select level, active low |
| csRst | input | 1 | One-cycle filtered chip-select reset pulse (clk domain) |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| din | input | 1 | Serial address input |
| dout | output | 1 | Serial result output |
| doutOe | output | 1 | Output enable for the three-state `dout` pad |
| eoc | output | 1 | End of conversion, low while a conversion is pending |
| convReq | output | 1 | One-cycle conversion request |
| convAddr | output | 4 | Channel for the requested conversion |
| convResult | input | 8 | Result from the converter, valid from `convDone` rising |
| convDone | input | 1 | Converter done; its rising edge completes a conversion |

## Verification
The case where two functions can fall in the same cycle is a chip-select reset pulse against the synchronised rising edge of the converter's done signal. The bench drives `convDone` by hand and places `csRst` at offsets of zero to three `clk` cycles after it. With two synchroniser stages, an offset of two lands in the exact cycle in which the done edge is acted on.

For each offset, the bench predicts whether the conversion is dropped (offsets up to two) or kept (offset three). It then judges the outcome from `eoc` and from the data shifted out in the following frame.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

  // Strobes from the sequencing control to the shift datapath.
  typedef struct packed {
    logic captureBit;  // shift one address bit in
    logic shiftOut;    // advance the output shifter by one bit
    logic startConv;   // latch the channel and issue a request
    logic loadResult;  // take converter result as new frame data
    logic reloadOut;   // rewind output shifter to the stored result
  } seqStrobes_t;

endpackage

// File: rtl/adcsp_sync.sv
module adcsp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= 1'b0;
        else       stage <= asyncIn;
      end
      assign syncOut = stage;
    end else begin : g_chain
      logic [STAGES-1:0] stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= {stage[STAGES-2:0], asyncIn};
      end
      assign syncOut = stage[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/adcsp_ctrl.sv
module adcsp_ctrl
  import adcsp_pkg::*;
#(
  parameter int ADDR_BITS  = 4,
  parameter int FRAME_BITS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        csRst,
  input  logic        sclkS,
  input  logic        doneS,
  output seqStrobes_t strb,
  output logic        eoc,
  output logic        doutOe,
  output logic        convReq
);

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_CYC = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_LIM = CNT_W'(ADDR_BITS);

  logic             sclkPrev;
  logic             donePrev;
  logic [CNT_W-1:0] cycCnt;
  logic             pending;

  logic sclkRise, sclkFall, doneRise;
  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign doneRise = doneS & ~donePrev;

  logic frameEnd;
  assign frameEnd = sclkFall && !pending && !csRst && (cycCnt == LAST_CYC);

  always_comb begin
    strb            = '0;
    strb.reloadOut  = csRst;
    strb.captureBit = sclkRise && !pending && !csRst && (cycCnt < ADDR_LIM);
    strb.shiftOut   = sclkFall && !pending && !csRst && (cycCnt != LAST_CYC);
    strb.startConv  = frameEnd;
    strb.loadResult = doneRise && pending && !csRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      donePrev <= 1'b0;
      cycCnt   <= '0;
      pending  <= 1'b0;
      convReq  <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      donePrev <= doneS;
      convReq  <= frameEnd;
      if (csRst) begin
        cycCnt  <= '0;
        pending <= 1'b0;
      end else if (pending) begin
        if (doneRise) pending <= 1'b0;
      end else if (sclkFall) begin
        if (cycCnt == LAST_CYC) begin
          cycCnt  <= '0;
          pending <= 1'b1;
        end else begin
          cycCnt <= cycCnt + 1'b1;
        end
      end
    end
  end

  assign eoc    = ~pending;
  assign doutOe = ~csN & ~pending;

endmodule

// File: rtl/adcsp_data.sv
module adcsp_data
  import adcsp_pkg::*;
#(
  parameter int ADDR_BITS  = 4,
  parameter int DATA_BITS  = 8,
  parameter int NUM_INPUTS = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dinS,
  input  seqStrobes_t          strb,
  input  logic [DATA_BITS-1:0] convResult,
  output logic                 dout,
  output logic [ADDR_BITS-1:0] convAddr
);

  localparam logic [ADDR_BITS-1:0] TEST_CODE = ADDR_BITS'(NUM_INPUTS);

  logic [ADDR_BITS-1:0] addrShift;
  logic [DATA_BITS-1:0] resultReg;
  logic [DATA_BITS-1:0] outShift;
  logic [ADDR_BITS-1:0] chanSel;

  // Reserved codes above the test channel fall back to the test channel.
  assign chanSel = (addrShift > TEST_CODE) ? TEST_CODE : addrShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrShift <= '0;
      convAddr  <= '0;
    end else begin
      if (strb.captureBit) addrShift <= {addrShift[ADDR_BITS-2:0], dinS};
      if (strb.startConv)  convAddr  <= chanSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      outShift  <= '0;
    end else if (strb.loadResult) begin
      resultReg <= convResult;
      outShift  <= convResult;
    end else if (strb.reloadOut) begin
      outShift <= resultReg;
    end else if (strb.shiftOut) begin
      outShift <= {outShift[DATA_BITS-2:0], 1'b0};
    end
  end

  assign dout = outShift[DATA_BITS-1];

endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adcsp_pkg::*;
#(
  parameter int ADDR_BITS   = 4,
  parameter int DATA_BITS   = 8,
  parameter int NUM_INPUTS  = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 csRst,
  input  logic                 sclk,
  input  logic                 din,
  output logic                 dout,
  output logic                 doutOe,
  output logic                 eoc,
  output logic                 convReq,
  output logic [ADDR_BITS-1:0] convAddr,
  input  logic [DATA_BITS-1:0] convResult,
  input  logic                 convDone
);

  localparam int FRAME_BITS = DATA_BITS;

  logic        sclkS, dinS, doneS;
  seqStrobes_t strb;

  adcsp_sync #(.STAGES(SYNC_STAGES)) uSyncSclk (
    .clk(clk), .rstN(rstN), .asyncIn(sclk), .syncOut(sclkS));
  adcsp_sync #(.STAGES(SYNC_STAGES)) uSyncDin (
    .clk(clk), .rstN(rstN), .asyncIn(din), .syncOut(dinS));
  adcsp_sync #(.STAGES(SYNC_STAGES)) uSyncDone (
    .clk(clk), .rstN(rstN), .asyncIn(convDone), .syncOut(doneS));

  adcsp_ctrl #(.ADDR_BITS(ADDR_BITS), .FRAME_BITS(FRAME_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .csRst(csRst),
    .sclkS(sclkS), .doneS(doneS), .strb(strb),
    .eoc(eoc), .doutOe(doutOe), .convReq(convReq));

  adcsp_data #(.ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS),
               .NUM_INPUTS(NUM_INPUTS)) uData (
    .clk(clk), .rstN(rstN), .dinS(dinS), .strb(strb),
    .convResult(convResult), .dout(dout), .convAddr(convAddr));

endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk #(
  parameter int ADDR_BITS  = 4,
  parameter int NUM_INPUTS = 11
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csRst,
  input logic                 dout,
  input logic                 doutOe,
  input logic                 eoc,
  input logic                 convReq,
  input logic [ADDR_BITS-1:0] convAddr
);

  // R3: a request lasts one cycle
  a_r3_single_req: assert property (@(posedge clk) disable iff (!rstN)
    convReq |=> !convReq);

  // R6: end-of-conversion is low when the request goes out
  a_r6_req_drops_eoc: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> !eoc);

  // R4: output enable is off once the frame has ended
  a_r4_oe_off_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> !doutOe);

  // R5: data output is frozen while a conversion is pending
  a_r5_dout_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!eoc && $past(!eoc)) |-> $stable(dout));

  // R7: requested channel never exceeds the test channel
  a_r7_addr_legal: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> (convAddr <= ADDR_BITS'(NUM_INPUTS)));

  // R9: chip-select reset releases end-of-conversion
  a_r9_rst_releases: assert property (@(posedge clk) disable iff (!rstN)
    $past(csRst) |-> eoc);

endmodule

bind adc_serial_seq adc_serial_seq_chk #(
  .ADDR_BITS(ADDR_BITS), .NUM_INPUTS(NUM_INPUTS)
) uChk (
  .clk(clk), .rstN(rstN), .csRst(csRst), .dout(dout), .doutOe(doutOe),
  .eoc(eoc), .convReq(convReq), .convAddr(convAddr));

// File: tb/tb_adc_serial_seq.sv
`timescale 1ns/1ps
module tb_adc_serial_seq;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       csRst = 1'b0;
  logic       sclk = 1'b0;
  logic       din = 1'b0;
  logic       dout, doutOe, eoc, convReq;
  logic [3:0] convAddr;
  logic [7:0] convResult = 8'h00;
  logic       convDone = 1'b0;

  int         nChecks = 0;
  int         nFails = 0;
  bit         finished = 1'b0;
  bit         autoDone = 1'b1;
  int         modelLat = 20;
  logic [7:0] prevResult = 8'h00;
  logic [3:0] addrQ[$];

  always #2.5 clk = ~clk;

  adc_serial_seq dut (
    .clk(clk), .rstN(rstN), .csN(csN), .csRst(csRst), .sclk(sclk), .din(din),
    .dout(dout), .doutOe(doutOe), .eoc(eoc), .convReq(convReq),
    .convAddr(convAddr), .convResult(convResult), .convDone(convDone));

  function automatic logic [7:0] modelConv(input logic [3:0] ch);
    return (ch == 4'd11) ? 8'h80 : {ch, ~ch};
  endfunction

  function automatic logic [3:0] mapAddr(input logic [3:0] a);
    return (a > 4'd11) ? 4'd11 : a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Converter model: answers a request after modelLat cycles.
  initial begin
    logic [3:0] pAddr;
    int         cnt;
    bit         busy;
    busy = 0;
    cnt = 0;
    pAddr = '0;
    forever begin
      @(negedge clk);
      if (convReq) begin
        pAddr = convAddr;
        cnt = modelLat;
        busy = autoDone;
      end else if (busy) begin
        cnt--;
        if (cnt == 0) begin
          convResult = modelConv(pAddr);
          convDone = 1'b1;
          waitClk(3);
          convDone = 1'b0;
          busy = 0;
        end
      end
    end
  end

  // Scoreboard monitor: pops the expected channel at every request.
  initial begin
    forever begin
      @(negedge clk);
      if (convReq) begin
        if (addrQ.size() == 0) begin
          check(1'b0, "R5 unexpected request", 1, 0);
        end else begin
          logic [3:0] e;
          e = addrQ.pop_front();
          check(convAddr == e, "R3/R7 request channel", convAddr, e);
        end
      end
    end
  end

  // One frame: address in, expected bits out. pauseAt>=0 stretches that cycle.
  task automatic runFrame(input logic [3:0] addr, input logic [7:0] expOut,
                          input int pauseAt, input string tag);
    for (int i = 0; i < 8; i++) begin
      din = (i < 4) ? addr[3-i] : ~addr[0];
      waitClk(HALF);
      check(dout == expOut[7-i], tag, dout, expOut[7-i]);
      check(doutOe == 1'b1, "R4 enable during frame", doutOe, 1);
      if (i == 7) addrQ.push_back(mapAddr(addr));
      sclk = 1'b1;
      waitClk((i == pauseAt) ? 300 : HALF);
      sclk = 1'b0;
    end
    waitClk(6);
    check(eoc == 1'b0, "R6 eoc low after eighth fall", eoc, 0);
    check(doutOe == 1'b0, "R4 enable off with csN low", doutOe, 0);
  endtask

  task automatic waitEoc();
    int t;
    t = 0;
    while (eoc !== 1'b1 && t < 2000) begin
      waitClk(1);
      t++;
    end
    check(eoc == 1'b1, "R6 eoc returns high", eoc, 1);
    waitClk(4);
  endtask

  task automatic fullFrame(input logic [3:0] addr, input string tag);
    runFrame(addr, prevResult, -1, tag);
    waitEoc();
    prevResult = modelConv(mapAddr(addr));
  endtask

  initial begin
    waitClk(5);
    // R10: reset state
    check(eoc == 1'b1, "R10 eoc after reset", eoc, 1);
    check(convReq == 1'b0, "R10 no request", convReq, 0);
    check(doutOe == 1'b0, "R4 enable off with csN high", doutOe, 0);
    rstN = 1'b1;
    waitClk(4);
    csN = 1'b0;
    waitClk(4);
    check(doutOe == 1'b1, "R4 enable with csN low", doutOe, 1);
    check(dout == 1'b0, "R10 stored result zero", dout, 0);

    // R1 R2 R3: several channel patterns
    fullFrame(4'd5, "R2 first frame output");
    fullFrame(4'd10, "R2 output of ch5");
    fullFrame(4'd0, "R1 output of ch10");
    fullFrame(4'd9, "R1 output of ch0");
    // R7: test channel and reserved codes
    fullFrame(4'd11, "R7 output of ch9");
    fullFrame(4'd13, "R7 test channel result");
    fullFrame(4'd15, "R7 reserved 13 result");
    fullFrame(4'd6, "R7 reserved 15 result");

    // R8: clock held high mid-frame
    runFrame(4'd3, prevResult, 2, "R8 stretched frame output");
    waitEoc();
    prevResult = modelConv(4'd3);
    fullFrame(4'd1, "R8 result after stretched frame");

    // R5: clock activity while a conversion is pending
    modelLat = 300;
    runFrame(4'd7, prevResult, -1, "R5 frame before lockout");
    for (int k = 0; k < 6; k++) begin
      din = k[0];
      sclk = 1'b1; waitClk(HALF);
      sclk = 1'b0; waitClk(HALF);
    end
    check(eoc == 1'b0, "R5 still pending", eoc, 0);
    check(doutOe == 1'b0, "R5 enable stays off", doutOe, 0);
    waitEoc();
    modelLat = 20;
    prevResult = modelConv(4'd7);
    fullFrame(4'd2, "R5 no shift during lockout");

    // R9: reset mid-frame clears the bit count
    for (int i = 0; i < 5; i++) begin
      din = 1'b1;
      waitClk(HALF); sclk = 1'b1;
      waitClk(HALF); sclk = 1'b0;
    end
    waitClk(2);
    csRst = 1'b1; waitClk(1); csRst = 1'b0;
    waitClk(4);
    check(eoc == 1'b1, "R9 eoc high after reset", eoc, 1);
    check(dout == prevResult[7], "R9 output rewound", dout, prevResult[7]);
    fullFrame(4'd4, "R9 full frame after reset");

    // R9 vs R6: reset pulse against the done edge at offsets 0..3
    for (int d = 0; d < 4; d++) begin
      logic [3:0] a;
      a = 4'(8 + d);
      autoDone = 1'b0;
      runFrame(a, prevResult, -1, "R9 frame before race");
      waitClk(10);
      convResult = modelConv(mapAddr(a));
      convDone = 1'b1;
      waitClk(d);
      csRst = 1'b1; waitClk(1); csRst = 1'b0;
      waitClk(3);
      convDone = 1'b0;
      waitClk(4);
      check(eoc == 1'b1, "R9 eoc high after race", eoc, 1);
      if (d >= 3) prevResult = modelConv(mapAddr(a));
      autoDone = 1'b1;
    end
    fullFrame(4'd12, "R9 race kept/dropped result");
    fullFrame(4'd0, "R7 reserved 12 result");

    csN = 1'b1;
    waitClk(4);
    check(doutOe == 1'b0, "R4 enable off with csN high", doutOe, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule